// File: doc/BRIEF.md
# Infrared Dongle Serial Configuration Master

This block is the configuration master for an external infrared transceiver dongle that is programmed over a slow two-wire bit-serial link. It drives a clock line and a data line toward the dongle. It also reads a returned data bit and an active-low line on which the dongle signals that read data is ready. A host-side request names one of four operations: an indexed register write, an indexed register read, a reset burst, or a power-up program. The power-up program resets the dongle, loads three of its registers and reads one of them back.

Every transaction is built from clock pulses. Each pulse is a low phase followed by a high phase, and each phase lasts a programmable number of system clocks. A transaction opens with a command byte that merges the 7-bit device address, the register index and a direction flag. A read then polls the ready line for a bounded number of pulses. If the dongle never answers, the read finishes with a timeout flag and zero data. The host sees a busy level while the block works. When the transaction ends, a one-cycle done pulse appears together with the read data and the timeout flag.

Top module: `dongle_cfg_master`

## Requirements
- R1: The command byte equals {0,address} OR (index shifted left by one) OR a direction bit in bit 0, where the direction bit is 1 for a write and 0 for a read. Every byte is sent least significant bit first. Each bit is placed on the data line during the low phase and is held through the following high phase, so the dongle takes it on the rising clock edge.
- R2: Inside a transaction every high phase, and every low phase between two pulses, lasts exactly `div_i` system clocks. A `div_i` of 0 acts as 1.
- R3: A write gives 18 rising clock edges: the command byte, then the data byte, then 2 pulses with data low. It ends with one low phase on the clock.
- R4: After its command byte a read drives data low and issues poll pulses, at most 10 of them. `rd_valid_ni` is sampled on the system clock edge that ends each poll pulse's high phase, and polling stops at the first pulse on which it is seen low.
- R5: After the ready line is seen low, a read captures 8 data bits from `rd_bit_i`, least significant bit first. Each bit is sampled on the edge that ends a high phase, which is the edge where the clock falls. Four trailing pulses with data low follow, so a read answered on poll pulse K gives 20+K rising edges. It returns the captured byte with the timeout flag at 0.
- R6: A read that sees no ready indication within 10 poll pulses issues 2 dummy pulses and then the 4 trailing pulses, 24 rising edges in total. It returns data 0x00 with the timeout flag at 1.
- R7: A dongle reset holds data low for 30 clock pulses and then leaves the clock low. It returns data 0 and timeout 0.
- R8: The power-up program runs five steps in this order: a reset; a write of command 0x41 with data 0x17; a write of 0x43 with `mode_i`; a write of 0x45 with 0xFF; and a read with command 0x42. A single done pulse comes at the end and carries the read-back byte. With the read answered on poll K, the program gives 104+K rising edges.
- R9: `op_i` encodes the operation as 0 write, 1 read, 2 reset and 3 power-up. A request is taken only while `busy_o` is low; a request raised during a transaction is dropped. `done_o` is high for exactly one cycle, in which `busy_o` is already low. `rdata_o` and `timeout_o` change only together with done and hold their values otherwise. While the block is idle, both link lines are low.
- R10: After reset `busy_o`, `done_o`, `sclk_o`, `sdat_o`, `rdata_o` and `timeout_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Half-period of the link clock in system clocks (0 acts as 1) |
| req_i | input | 1 | Request strobe, taken while busy is low |
| op_i | input | 2 | Operation: 0 write, 1 read, 2 reset, 3 power-up |
| addr_i | input | 7 | Device address |
| index_i | input | 7 | Register index |
| wdata_i | input | 8 | Write data |
| mode_i | input | 8 | Mode value loaded by the power-up program |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | 8 | Read result, updated with done |
| timeout_o | output | 1 | Read saw no ready indication, updated with done |
| sclk_o | output | 1 | Link clock to the dongle |
| sdat_o | output | 1 | Link data to the dongle |
| rd_bit_i | input | 1 | Read data bit from the dongle |
| rd_valid_ni | input | 1 | Active-low read-ready from the dongle |

## Verification
The bench plays the part of the dongle. It records the data line on every rising clock edge and answers reads on a chosen poll pulse. Writes are run with differing address, index and data values, which separates the direction bit, the index shift and the bit order of the command. Reads are answered on the first and on the tenth poll pulse, which checks the early stop and the last allowed pulse. A read that is never answered shows the dummy path and the timeout. The power-up program is checked for step order and data placement over the whole edge stream. A request raised during a transaction checks that it is dropped, and two divider settings, including zero, check the phase widths.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_RESET = 2'd2,
    OP_BOOT  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FK_WRITE = 2'd0,
    FK_READ  = 2'd1,
    FK_RESET = 2'd2
  } frame_e;

  typedef enum logic [3:0] {
    SEG_IDLE, SEG_CMD, SEG_WDAT, SEG_WTAIL, SEG_POLL,
    SEG_RDAT, SEG_RDUMMY, SEG_RTAIL, SEG_RST, SEG_FIN
  } seg_e;

  localparam logic [ADDR_W-1:0] BOOT_ADDR = 7'h40;
  localparam logic [BYTE_W-1:0] BOOT_V0   = 8'h17;
  localparam logic [BYTE_W-1:0] BOOT_V2   = 8'hFF;
  localparam logic [2:0]        BOOT_LAST = 3'd4;

  function automatic logic [BYTE_W-1:0] pack_cmd(logic [ADDR_W-1:0] addr,
                                                 logic [ADDR_W-1:0] idx,
                                                 logic wr);
    return {1'b0, addr} | {idx, 1'b0} | {{(BYTE_W-1){1'b0}}, wr};
  endfunction
endpackage

// File: rtl/dcm_phase_timer.sv
module dcm_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             phase_end_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit       = (div_i == '0) ? DIV_W'(1) : div_i;
    phase_end_o = run_i && (cnt_q == limit - DIV_W'(1));
    if (!run_i || phase_end_o) cnt_d = '0;
    else                       cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dcm_frame_engine.sv
module dcm_frame_engine
  import dcm_pkg::*;
#(
  parameter int POLL_MAX   = 10,
  parameter int RST_PULSES = 30
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              start_i,
  input  frame_e            kind_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] wdat_i,
  input  logic              phase_end_i,
  input  logic              rd_bit_i,
  input  logic              rd_valid_ni,
  output logic              active_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              valid_seen_o,
  output logic              sclk_o,
  output logic              sdat_o
);
  localparam int MAXP  = (RST_PULSES > POLL_MAX) ?
                         ((RST_PULSES > BYTE_W) ? RST_PULSES : BYTE_W) :
                         ((POLL_MAX > BYTE_W) ? POLL_MAX : BYTE_W);
  localparam int CNT_W = $clog2(MAXP + 1);
  localparam int BIT_W = $clog2(BYTE_W);

  seg_e              seg_q, seg_d;
  frame_e            kind_q, kind_d;
  logic              half_q, half_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d, wdat_q, wdat_d, rdat_q, rdat_d;
  logic              vs_q, vs_d, done_q, done_d;
  logic              last;

  function automatic logic [CNT_W-1:0] seg_len(seg_e s);
    case (s)
      SEG_CMD, SEG_WDAT, SEG_RDAT: return CNT_W'(BYTE_W);
      SEG_WTAIL, SEG_RDUMMY:       return CNT_W'(2);
      SEG_POLL:                    return CNT_W'(POLL_MAX);
      SEG_RTAIL:                   return CNT_W'(4);
      SEG_RST:                     return CNT_W'(RST_PULSES);
      default:                     return CNT_W'(1);
    endcase
  endfunction

  always_comb begin
    last   = (cnt_q == seg_len(seg_q) - CNT_W'(1));
    seg_d  = seg_q;
    kind_d = kind_q;
    half_d = half_q;
    cnt_d  = cnt_q;
    cmd_d  = cmd_q;
    wdat_d = wdat_q;
    rdat_d = rdat_q;
    vs_d   = vs_q;
    done_d = 1'b0;
    if (seg_q == SEG_IDLE) begin
      if (start_i) begin
        seg_d  = (kind_i == FK_RESET) ? SEG_RST : SEG_CMD;
        kind_d = kind_i;
        half_d = 1'b0;
        cnt_d  = '0;
        cmd_d  = cmd_i;
        wdat_d = wdat_i;
        rdat_d = '0;
        vs_d   = 1'b0;
      end
    end else if (seg_q == SEG_FIN) begin
      if (phase_end_i) begin
        seg_d  = SEG_IDLE;
        done_d = 1'b1;
      end
    end else if (phase_end_i) begin
      if (!half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        cnt_d  = cnt_q + CNT_W'(1);
        case (seg_q)
          SEG_CMD: if (last) begin
            cnt_d = '0;
            seg_d = (kind_q == FK_READ) ? SEG_POLL : SEG_WDAT;
          end
          SEG_WDAT:  if (last) begin cnt_d = '0; seg_d = SEG_WTAIL; end
          SEG_WTAIL: if (last) begin cnt_d = '0; seg_d = SEG_FIN;   end
          SEG_POLL: begin
            if (!rd_valid_ni) begin
              vs_d  = 1'b1;
              cnt_d = '0;
              seg_d = SEG_RDAT;
            end else if (last) begin
              cnt_d = '0;
              seg_d = SEG_RDUMMY;
            end
          end
          SEG_RDAT: begin
            rdat_d[cnt_q[BIT_W-1:0]] = rd_bit_i;
            if (last) begin cnt_d = '0; seg_d = SEG_RTAIL; end
          end
          SEG_RDUMMY: if (last) begin cnt_d = '0; seg_d = SEG_RTAIL; end
          SEG_RTAIL:  if (last) begin cnt_d = '0; seg_d = SEG_FIN;   end
          SEG_RST:    if (last) begin cnt_d = '0; seg_d = SEG_FIN;   end
          default:    seg_d = SEG_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_IDLE;
      kind_q <= FK_WRITE;
      half_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      vs_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      kind_q <= kind_d;
      half_q <= half_d;
      cnt_q  <= cnt_d;
      cmd_q  <= cmd_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
      vs_q   <= vs_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    case (seg_q)
      SEG_CMD:  sdat_o = cmd_q[cnt_q[BIT_W-1:0]];
      SEG_WDAT: sdat_o = wdat_q[cnt_q[BIT_W-1:0]];
      default:  sdat_o = 1'b0;
    endcase
  end

  assign sclk_o       = half_q;
  assign active_o     = (seg_q != SEG_IDLE);
  assign done_o       = done_q;
  assign rdata_o      = rdat_q;
  assign valid_seen_o = vs_q;
endmodule

// File: rtl/dcm_txn_ctrl.sv
module dcm_txn_ctrl
  import dcm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              req_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] mode_i,
  input  logic              f_done_i,
  input  logic [BYTE_W-1:0] f_rdata_i,
  input  logic              f_valid_i,
  output logic              f_start_o,
  output frame_e            f_kind_o,
  output logic [BYTE_W-1:0] f_cmd_o,
  output logic [BYTE_W-1:0] f_wdat_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              timeout_o
);
  logic              busy_q, busy_d, boot_q, boot_d, launch_q, launch_d;
  logic              done_q, done_d, tmo_q, tmo_d;
  logic [2:0]        step_q, step_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d, idx_q, idx_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d, mode_q, mode_d, rdata_q, rdata_d;
  logic              accept;

  // Frame selection: a single operation maps directly; the power-up
  // program walks its five steps.
  always_comb begin
    f_kind_o = FK_WRITE;
    f_cmd_o  = pack_cmd(addr_q, idx_q, 1'b1);
    f_wdat_o = wdata_q;
    if (boot_q) begin
      case (step_q)
        3'd0: f_kind_o = FK_RESET;
        3'd1: begin
          f_cmd_o  = pack_cmd(BOOT_ADDR, 7'd0, 1'b1);
          f_wdat_o = BOOT_V0;
        end
        3'd2: begin
          f_cmd_o  = pack_cmd(BOOT_ADDR, 7'd1, 1'b1);
          f_wdat_o = mode_q;
        end
        3'd3: begin
          f_cmd_o  = pack_cmd(BOOT_ADDR, 7'd2, 1'b1);
          f_wdat_o = BOOT_V2;
        end
        default: begin
          f_kind_o = FK_READ;
          f_cmd_o  = pack_cmd(BOOT_ADDR, 7'd1, 1'b0);
        end
      endcase
    end else begin
      case (op_q)
        OP_READ: begin
          f_kind_o = FK_READ;
          f_cmd_o  = pack_cmd(addr_q, idx_q, 1'b0);
        end
        OP_RESET: f_kind_o = FK_RESET;
        default:  f_kind_o = FK_WRITE;
      endcase
    end
  end

  always_comb begin
    accept   = req_i && !busy_q;
    busy_d   = busy_q;
    boot_d   = boot_q;
    step_d   = step_q;
    op_d     = op_q;
    addr_d   = addr_q;
    idx_d    = idx_q;
    wdata_d  = wdata_q;
    mode_d   = mode_q;
    rdata_d  = rdata_q;
    tmo_d    = tmo_q;
    launch_d = 1'b0;
    done_d   = 1'b0;
    if (accept) begin
      busy_d   = 1'b1;
      launch_d = 1'b1;
      boot_d   = (op_i == OP_BOOT);
      step_d   = 3'd0;
      op_d     = op_i;
      addr_d   = addr_i;
      idx_d    = index_i;
      wdata_d  = wdata_i;
      mode_d   = mode_i;
    end else if (busy_q && f_done_i) begin
      if (boot_q && (step_q != BOOT_LAST)) begin
        step_d   = step_q + 3'd1;
        launch_d = 1'b1;
      end else begin
        busy_d  = 1'b0;
        boot_d  = 1'b0;
        done_d  = 1'b1;
        rdata_d = (f_kind_o == FK_READ) ? f_rdata_i : '0;
        tmo_d   = (f_kind_o == FK_READ) && !f_valid_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      boot_q   <= 1'b0;
      step_q   <= '0;
      op_q     <= OP_WRITE;
      addr_q   <= '0;
      idx_q    <= '0;
      wdata_q  <= '0;
      mode_q   <= '0;
      rdata_q  <= '0;
      tmo_q    <= 1'b0;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      boot_q   <= boot_d;
      step_q   <= step_d;
      op_q     <= op_d;
      addr_q   <= addr_d;
      idx_q    <= idx_d;
      wdata_q  <= wdata_d;
      mode_q   <= mode_d;
      rdata_q  <= rdata_d;
      tmo_q    <= tmo_d;
      launch_q <= launch_d;
      done_q   <= done_d;
    end
  end

  assign f_start_o = launch_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/dongle_cfg_master.sv
module dongle_cfg_master
  import dcm_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int POLL_MAX   = 10,
  parameter int RST_PULSES = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             req_i,
  input  logic [1:0]       op_i,
  input  logic [6:0]       addr_i,
  input  logic [6:0]       index_i,
  input  logic [7:0]       wdata_i,
  input  logic [7:0]       mode_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rdata_o,
  output logic             timeout_o,
  output logic             sclk_o,
  output logic             sdat_o,
  input  logic             rd_bit_i,
  input  logic             rd_valid_ni
);
  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              f_start, f_active, f_done, f_valid, phase_end;
  frame_e            f_kind;
  logic [BYTE_W-1:0] f_cmd, f_wdat, f_rdata;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  dcm_txn_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .op_i      (op_e'(op_i)),
    .addr_i    (addr_i),
    .index_i   (index_i),
    .wdata_i   (wdata_i),
    .mode_i    (mode_i),
    .f_done_i  (f_done),
    .f_rdata_i (f_rdata),
    .f_valid_i (f_valid),
    .f_start_o (f_start),
    .f_kind_o  (f_kind),
    .f_cmd_o   (f_cmd),
    .f_wdat_o  (f_wdat),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o),
    .timeout_o (timeout_o)
  );

  dcm_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .run_i       (f_active),
    .div_i       (div_i),
    .phase_end_o (phase_end)
  );

  dcm_frame_engine #(
    .POLL_MAX   (POLL_MAX),
    .RST_PULSES (RST_PULSES)
  ) u_frame (
    .clk_i        (clk_i),
    .rst_n        (rst_n),
    .start_i      (f_start),
    .kind_i       (f_kind),
    .cmd_i        (f_cmd),
    .wdat_i       (f_wdat),
    .phase_end_i  (phase_end),
    .rd_bit_i     (rd_bit_i),
    .rd_valid_ni  (rd_valid_ni),
    .active_o     (f_active),
    .done_o       (f_done),
    .rdata_o      (f_rdata),
    .valid_seen_o (f_valid),
    .sclk_o       (sclk_o),
    .sdat_o       (sdat_o)
  );
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker (
  input logic       clk_i,
  input logic       rst_n,
  input logic       req_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] rdata_o,
  input logic       timeout_o,
  input logic       sclk_o,
  input logic       sdat_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> !busy_o); // R9
  AST_IDLE_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !sdat_o)); // R9
  AST_BUSY_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_i)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !done_o |-> ($stable(rdata_o) && $stable(timeout_o))); // R9
  AST_TIMEOUT_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && timeout_o) |-> (rdata_o == 8'h00)); // R6
endmodule

bind dongle_cfg_master dcm_checker u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rdata_o   (rdata_o),
  .timeout_o (timeout_o),
  .sclk_o    (sclk_o),
  .sdat_o    (sdat_o)
);

// File: tb/tb_dongle_cfg_master.sv
`timescale 1ns/1ps
module tb_dongle_cfg_master;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_i = 8'd1;
  logic       req_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [6:0] addr_i = '0, index_i = '0;
  logic [7:0] wdata_i = '0, mode_i = '0;
  logic       busy_o, done_o, timeout_o, sclk_o, sdat_o;
  logic [7:0] rdata_o;
  logic       rd_bit_i = 1'b0;
  logic       rd_valid_ni = 1'b1;

  dongle_cfg_master dut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  // dongle model state
  int   edge_cnt = 0;
  logic bits [0:255];
  int   poll_k = 0, rd_base = 0;
  logic [7:0] rsp = '0;
  // phase width monitor
  int hi_run = 0, lo_run = 0, hi_min, hi_max, lo_min, lo_max;
  logic prev_clk = 1'b0, in_low = 1'b0;
  // transaction results
  logic [7:0] got_rdata;
  logic got_tmo, done_dropped, got_done;
  int inject_at = -1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] cap_byte(input int off);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = bits[off+i];
    return b;
  endfunction

  function automatic int ones_in(input int off, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (bits[off+i]) c++;
    return c;
  endfunction

  // Dongle model: records data on rising clock, answers reads.
  initial forever begin
    @(posedge sclk_o);
    if (edge_cnt < 256) bits[edge_cnt] = sdat_o;
    edge_cnt++;
    if (poll_k > 0 && edge_cnt == rd_base + 8 + poll_k) rd_valid_ni = 1'b0;
    if (poll_k > 0 && edge_cnt >= rd_base + 9 + poll_k && edge_cnt <= rd_base + 16 + poll_k)
      rd_bit_i = rsp[edge_cnt - (rd_base + 9 + poll_k)];
  end

  // Phase width monitor
  initial forever begin
    @(negedge clk_i);
    if (sclk_o) begin
      if (!prev_clk && in_low) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
      end
      lo_run = 0; in_low = 1'b0;
      hi_run++;
    end else begin
      if (prev_clk) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0; in_low = 1'b1;
      end
      if (in_low) lo_run++;
      if (!busy_o) begin in_low = 1'b0; lo_run = 0; end
    end
    prev_clk = sclk_o;
  end

  task automatic run_txn(input logic [1:0] op, input logic [6:0] a, input logic [6:0] ix,
                         input logic [7:0] wd, input logic [7:0] md, input int k,
                         input int base, input logic [7:0] r);
    int n;
    edge_cnt = 0; poll_k = k; rd_base = base; rsp = r;
    rd_valid_ni = 1'b1; rd_bit_i = 1'b0;
    hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
    got_done = 1'b0;
    @(negedge clk_i);
    req_i = 1'b1; op_i = op; addr_i = a; index_i = ix; wdata_i = wd; mode_i = md;
    @(negedge clk_i);
    req_i = 1'b0;
    n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk_i);
      n++;
      if (n == inject_at) begin
        req_i = 1'b1; op_i = 2'd1; addr_i = 7'h2A; index_i = 7'h11;
      end else begin
        req_i = 1'b0;
      end
    end
    req_i = 1'b0;
    got_done = done_o; got_rdata = rdata_o; got_tmo = timeout_o;
    @(negedge clk_i);
    done_dropped = !done_o && !busy_o;
  endtask

  task automatic t_reset_state;
    chk(busy_o == 0 && done_o == 0, "R10 busy/done", {busy_o, done_o}, 0);
    chk(sclk_o == 0 && sdat_o == 0, "R10 link lines", {sclk_o, sdat_o}, 0);
    chk(rdata_o == 0 && timeout_o == 0, "R10 result", {timeout_o, rdata_o}, 0);
  endtask

  task automatic t_write(input logic [7:0] dv, input logic [6:0] a, input logic [6:0] ix,
                         input logic [7:0] wd);
    logic [7:0] ecmd;
    int eff;
    eff = (dv == 0) ? 1 : int'(dv);
    div_i = dv;
    ecmd = {1'b0, a} | {ix, 1'b0} | 8'h01;
    run_txn(2'd0, a, ix, wd, 8'h00, 0, 0, 8'h00);
    chk(got_done, "R9 write done", got_done, 1);
    chk(edge_cnt == 18, "R3 write edge count", edge_cnt, 18);
    chk(cap_byte(0) == ecmd, "R1 write command byte", cap_byte(0), ecmd);
    chk(cap_byte(8) == wd, "R3 write data byte", cap_byte(8), wd);
    chk(ones_in(16, 2) == 0, "R3 trailing pulses data low", ones_in(16, 2), 0);
    chk(hi_min == eff && hi_max == eff, "R2 high phase width", hi_max, eff);
    chk(lo_min == eff && lo_max == eff, "R2 low phase width", lo_max, eff);
    chk(done_dropped && sclk_o == 0, "R9 done one cycle, clock low", done_dropped, 1);
    chk(got_rdata == 0 && got_tmo == 0, "R9 write result", {got_tmo, got_rdata}, 0);
  endtask

  task automatic t_read(input logic [6:0] a, input logic [6:0] ix, input int k,
                        input logic [7:0] r);
    logic [7:0] ecmd;
    div_i = 8'd2;
    ecmd = {1'b0, a} | {ix, 1'b0};
    run_txn(2'd1, a, ix, 8'h00, 8'h00, k, 0, r);
    chk(cap_byte(0) == ecmd, "R1 read command byte", cap_byte(0), ecmd);
    chk(edge_cnt == 20 + k, "R4 R5 read edge count", edge_cnt, 20 + k);
    chk(ones_in(8, edge_cnt - 8) == 0, "R4 read data line low", ones_in(8, edge_cnt - 8), 0);
    chk(got_rdata == r, "R5 read data", got_rdata, r);
    chk(got_tmo == 0, "R5 no timeout", got_tmo, 0);
    chk(hi_min == 2 && hi_max == 2, "R2 read high width", hi_max, 2);
  endtask

  task automatic t_read_timeout;
    div_i = 8'd1;
    run_txn(2'd1, 7'h40, 7'h01, 8'h00, 8'h00, 0, 0, 8'hFF);
    chk(edge_cnt == 24, "R6 timeout edge count", edge_cnt, 24);
    chk(got_tmo == 1, "R6 timeout flag", got_tmo, 1);
    chk(got_rdata == 0, "R6 timeout data", got_rdata, 0);
  endtask

  task automatic t_dongle_reset;
    div_i = 8'd1;
    run_txn(2'd2, 7'h00, 7'h00, 8'h00, 8'h00, 0, 0, 8'h00);
    chk(edge_cnt == 30, "R7 reset pulse count", edge_cnt, 30);
    chk(ones_in(0, 30) == 0, "R7 reset data low", ones_in(0, 30), 0);
    chk(got_rdata == 0 && got_tmo == 0, "R7 reset clears result", {got_tmo, got_rdata}, 0);
    chk(sclk_o == 0, "R7 clock left low", sclk_o, 0);
  endtask

  task automatic t_boot(input logic [7:0] md, input int k, input logic [7:0] r);
    div_i = 8'd1;
    run_txn(2'd3, 7'h00, 7'h00, 8'h00, md, k, 84, r);
    chk(edge_cnt == 104 + k, "R8 power-up edge count", edge_cnt, 104 + k);
    chk(ones_in(0, 30) == 0, "R8 reset step", ones_in(0, 30), 0);
    chk(cap_byte(30) == 8'h41 && cap_byte(38) == 8'h17, "R8 step index 0",
        {cap_byte(30), cap_byte(38)}, 16'h4117);
    chk(cap_byte(48) == 8'h43 && cap_byte(56) == md, "R8 step index 1",
        {cap_byte(48), cap_byte(56)}, {8'h43, md});
    chk(cap_byte(66) == 8'h45 && cap_byte(74) == 8'hFF, "R8 step index 2",
        {cap_byte(66), cap_byte(74)}, 16'h45FF);
    chk(cap_byte(84) == 8'h42, "R8 readback command", cap_byte(84), 8'h42);
    chk(got_rdata == r && got_tmo == 0, "R8 readback data", got_rdata, r);
    chk(done_dropped, "R8 single done", done_dropped, 1);
  endtask

  task automatic t_busy_ignore;
    div_i = 8'd2;
    inject_at = 20;
    run_txn(2'd0, 7'h12, 7'h05, 8'h3C, 8'h00, 0, 0, 8'h00);
    inject_at = -1;
    chk(edge_cnt == 18, "R9 busy request dropped (edges)", edge_cnt, 18);
    chk(cap_byte(0) == 8'h1B && cap_byte(8) == 8'h3C, "R9 busy request dropped (frame)",
        {cap_byte(0), cap_byte(8)}, 16'h1B3C);
    repeat (4) @(negedge clk_i);
    chk(busy_o == 0 && edge_cnt == 18, "R9 no queued request", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset_state();
    t_write(8'd3, 7'h40, 7'h02, 8'hA5);
    t_write(8'd0, 7'h05, 7'h30, 8'h01);
    t_read(7'h40, 7'h01, 1, 8'hC3);
    t_read(7'h20, 7'h07, 10, 8'h5A);
    t_read_timeout();
    t_dongle_reset();
    t_boot(8'h6E, 3, 8'h6E);
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule